// File: doc/BRIEF.md
# FPGA Configuration Loader

This block copies a configuration image from a byte-wide parallel ROM into a target FPGA through its serial configuration port. A new load starts in two ways: a push button, passed through a debouncer, or the target pulling its init line low. In both cases the loader pulses the target's program line low, waits for the target to release init, and then walks the ROM from address zero. Each byte is shifted out most significant bit first, one bit per configuration clock pulse. After the last byte the loader gives extra clock pulses until the target reports done, or until a timeout runs out.

When it has finished or failed, the loader idles. It stays idle until the target or the button asks for a new load. Only after a successful load does the chip switch to I/O mode. In I/O mode a small bank with one control register and one status register becomes writable. A separate CPU reset clears that bank only, and never disturbs the loader.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs are: `tgt_prog_n_o` high, `tgt_cclk_o` low, `cfg_done_o`, `cfg_err_o` and `io_mode_o` low.
- R2: A new load can start only from idle, on a debounced press or a low `tgt_init_n_i`. It starts with exactly one clock cycle of `tgt_prog_n_o` low. No configuration clock pulse is given until `tgt_init_n_i` is high again.
- R3: A press counts only after `btn_i` (through a two-flop synchroniser) has been high for DB_CYCLES consecutive clocks. A shorter pulse starts nothing.
- R4: Bytes are read at ROM addresses 0 to IMG_BYTES-1 in ascending order. The ROM has one cycle of read latency. Each byte appears on `tgt_dout_o` MSB first, one bit per `tgt_cclk_o` pulse. Each pulse is high for one clock, and the data bit is stable at its rising edge.
- R5: If `tgt_done_i` goes high during the extra pulses after the last byte, the loader ends with `cfg_done_o`=1 and `cfg_err_o`=0. `cfg_done_o` and `cfg_err_o` are never high together.
- R6: If `tgt_done_i` stays low, exactly DONE_TMO extra pulses follow the last data bit. The loader then sets `cfg_err_o`.
- R7: If `tgt_init_n_i` goes low while bits are being shifted, the loader sets `cfg_err_o` and stops the configuration clock.
- R8: In idle, no configuration clock pulse and no program pulse is given. `cfg_done_o` and `cfg_err_o` keep their values until the next load begins shifting.
- R9: `io_mode_o` is high only when the loader is idle after a successful load. In that mode no configuration clock pulse or program pulse is given. When `io_mode_o` is low, writes and events are ignored.
- R10: `io_addr_i`=0 selects the control register, which is read/write. `io_addr_i`=1 selects the status register. Each cycle in I/O mode, the status register ORs in `io_evt_i`. A write to the status register clears the bits written as 1. `io_rdata_o` returns the selected register.
- R11: A low `cpu_rst_n` clears both I/O registers. It changes nothing in the loader: `cfg_done_o` and `io_mode_o` are kept, and no load starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| cpu_rst_n | input | 1 | Asynchronous active-low reset of the I/O registers only |
| btn_i | input | 1 | Raw hard-reset push button, active high |
| tgt_init_n_i | input | 1 | Target init line; low means request, or error while shifting |
| tgt_done_i | input | 1 | Target reports configuration complete |
| tgt_prog_n_o | output | 1 | Program pulse to the target, active low |
| tgt_cclk_o | output | 1 | Configuration clock to the target |
| tgt_dout_o | output | 1 | Serial configuration data |
| rom_addr_o | output | ADDR_W | ROM byte address |
| rom_data_i | input | 8 | ROM data, one cycle after the address |
| cfg_done_o | output | 1 | Last load succeeded |
| cfg_err_o | output | 1 | Last load failed |
| io_mode_o | output | 1 | Chip is in I/O mode |
| io_we_i | input | 1 | I/O register write strobe |
| io_addr_i | input | 1 | I/O register select |
| io_wdata_i | input | REG_W | I/O write data |
| io_evt_i | input | REG_W | Status event bits |
| io_rdata_o | output | REG_W | I/O read data |

## Verification
The assertions check on every cycle that:
- the program pulse lasts one cycle and the configuration clock is high for one cycle;
- the data bit holds across each rising clock edge;
- the ROM address only steps by one or returns to zero;
- done and error are never high together;
- I/O mode is quiet on the target pins;
- the I/O registers read zero while the CPU reset is held.

Only the bench scenarios can show the following:
- the full MSB-first bit order against the ROM contents;
- the exact number of timeout pulses;
- that a short button glitch is ignored;
- that an abort by the init line stops the clock;
- that a CPU reset leaves a finished load untouched;
- the write-1-to-clear behaviour of the status register.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_WAIT,
    S_FETCH,
    S_LOAD,
    S_SHIFT,
    S_DONE
  } cfgl_state_e;
endpackage

// File: rtl/cfgl_debounce.sv
module cfgl_debounce #(
  parameter int DB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic press_o
);
  localparam int CW = $clog2(DB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DB_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          stable_q, stable_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          press_q;

  // a level change is accepted after DB_CYCLES consecutive differing samples
  always_comb begin
    cnt_d    = '0;
    stable_d = stable_q;
    if (sync_q[1] != stable_q) begin
      if (cnt_q == CNT_LAST) begin
        stable_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], raw_i};
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
      press_q  <= stable_d & ~stable_q;
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
  import cfgl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IMG_BYTES = 16,
  parameter int DONE_TMO  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              press_i,
  input  logic              init_n_i,
  input  logic              done_i,
  input  logic [7:0]        rom_data_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              prog_n_o,
  output logic              cclk_o,
  output logic              dout_o,
  output logic              cfg_done_o,
  output logic              cfg_err_o,
  output logic              io_mode_o
);
  localparam int TW = $clog2(DONE_TMO + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_BYTES - 1);
  localparam logic [TW-1:0]     TMO_LAST  = TW'(DONE_TMO - 1);

  cfgl_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        sr_q, sr_d;
  logic [2:0]        bit_q, bit_d;
  logic              ph_q, ph_d;
  logic [TW-1:0]     tmo_q, tmo_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    sr_d    = sr_q;
    bit_d   = bit_q;
    ph_d    = ph_q;
    tmo_d   = tmo_q;
    done_d  = done_q;
    err_d   = err_q;
    unique case (state_q)
      S_IDLE: begin
        if (press_i || !init_n_i) begin
          state_d = S_PROG;
          addr_d  = '0;
        end
      end
      S_PROG: state_d = S_WAIT;
      S_WAIT: begin
        if (init_n_i) begin
          state_d = S_FETCH;
          done_d  = 1'b0;
          err_d   = 1'b0;
        end
      end
      S_FETCH: state_d = S_LOAD;
      S_LOAD: begin
        sr_d    = rom_data_i;
        bit_d   = '0;
        ph_d    = 1'b0;
        state_d = S_SHIFT;
      end
      S_SHIFT: begin
        if (!init_n_i) begin
          err_d   = 1'b1;
          ph_d    = 1'b0;
          state_d = S_IDLE;
        end else if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d  = 1'b0;
          sr_d  = {sr_q[6:0], 1'b0};
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            addr_d = addr_q + 1'b1;
            if (addr_q == LAST_ADDR) begin
              state_d = S_DONE;
              tmo_d   = '0;
            end else begin
              state_d = S_FETCH;
            end
          end
        end
      end
      S_DONE: begin
        if (done_i) begin
          done_d  = 1'b1;
          ph_d    = 1'b0;
          state_d = S_IDLE;
        end else if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (tmo_q == TMO_LAST) begin
            err_d   = 1'b1;
            state_d = S_IDLE;
          end else begin
            tmo_d = tmo_q + 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      sr_q    <= '0;
      bit_q   <= '0;
      ph_q    <= 1'b0;
      tmo_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      sr_q    <= sr_d;
      bit_q   <= bit_d;
      ph_q    <= ph_d;
      tmo_q   <= tmo_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign rom_addr_o = addr_q;
  assign prog_n_o   = (state_q != S_PROG);
  assign cclk_o     = ph_q;
  assign dout_o     = sr_q[7];
  assign cfg_done_o = done_q;
  assign cfg_err_o  = err_q;
  assign io_mode_o  = (state_q == S_IDLE) && done_q;
endmodule

// File: rtl/cfgl_iobank.sv
module cfgl_iobank #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] evt_i,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [REG_W-1:0] stat_q, stat_d;
  logic [REG_W-1:0] clr_mask;

  always_comb begin
    ctrl_d   = ctrl_q;
    stat_d   = stat_q;
    clr_mask = (we_i && addr_i) ? wdata_i : '0;
    if (en_i) begin
      if (we_i && !addr_i) ctrl_d = wdata_i;
      stat_d = (stat_q & ~clr_mask) | evt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  assign rdata_o = addr_i ? stat_q : ctrl_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int ADDR_W    = 8,
  parameter int IMG_BYTES = 16,
  parameter int DB_CYCLES = 16,
  parameter int DONE_TMO  = 32,
  parameter int REG_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rst_n,
  input  logic              btn_i,
  input  logic              tgt_init_n_i,
  input  logic              tgt_done_i,
  output logic              tgt_prog_n_o,
  output logic              tgt_cclk_o,
  output logic              tgt_dout_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic              cfg_done_o,
  output logic              cfg_err_o,
  output logic              io_mode_o,
  input  logic              io_we_i,
  input  logic              io_addr_i,
  input  logic [REG_W-1:0]  io_wdata_i,
  input  logic [REG_W-1:0]  io_evt_i,
  output logic [REG_W-1:0]  io_rdata_o
);
  logic [1:0] core_rst_q;
  logic [1:0] bank_rst_q;
  logic [1:0] init_q;
  logic [1:0] done_q;
  logic       bank_arst_n;
  logic       press;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_rst_q <= '0;
    else        core_rst_q <= {core_rst_q[0], 1'b1};
  end

  assign bank_arst_n = rst_n & cpu_rst_n;

  always_ff @(posedge clk or negedge bank_arst_n) begin
    if (!bank_arst_n) bank_rst_q <= '0;
    else              bank_rst_q <= {bank_rst_q[0], 1'b1};
  end

  // target status lines are asynchronous to clk
  always_ff @(posedge clk or negedge core_rst_q[1]) begin
    if (!core_rst_q[1]) begin
      init_q <= 2'b11;
      done_q <= 2'b00;
    end else begin
      init_q <= {init_q[0], tgt_init_n_i};
      done_q <= {done_q[0], tgt_done_i};
    end
  end

  cfgl_debounce #(.DB_CYCLES(DB_CYCLES)) u_deb (
    .clk    (clk),
    .rst_n  (core_rst_q[1]),
    .raw_i  (btn_i),
    .press_o(press)
  );

  cfgl_seq #(
    .ADDR_W   (ADDR_W),
    .IMG_BYTES(IMG_BYTES),
    .DONE_TMO (DONE_TMO)
  ) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_q[1]),
    .press_i   (press),
    .init_n_i  (init_q[1]),
    .done_i    (done_q[1]),
    .rom_data_i(rom_data_i),
    .rom_addr_o(rom_addr_o),
    .prog_n_o  (tgt_prog_n_o),
    .cclk_o    (tgt_cclk_o),
    .dout_o    (tgt_dout_o),
    .cfg_done_o(cfg_done_o),
    .cfg_err_o (cfg_err_o),
    .io_mode_o (io_mode_o)
  );

  cfgl_iobank #(.REG_W(REG_W)) u_bank (
    .clk    (clk),
    .rst_n  (bank_rst_q[1]),
    .en_i   (io_mode_o),
    .we_i   (io_we_i),
    .addr_i (io_addr_i),
    .wdata_i(io_wdata_i),
    .evt_i  (io_evt_i),
    .rdata_o(io_rdata_o)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rst_n,
  input logic              tgt_prog_n_o,
  input logic              tgt_cclk_o,
  input logic              tgt_dout_o,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              cfg_done_o,
  input logic              cfg_err_o,
  input logic              io_mode_o,
  input logic [REG_W-1:0]  io_rdata_o
);
  p_prog_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_prog_n_o |=> tgt_prog_n_o);

  p_cclk_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_cclk_o |=> !tgt_cclk_o);

  p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_cclk_o) |-> $stable(tgt_dout_o));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_addr_o != $past(rom_addr_o)) |->
      (rom_addr_o == ADDR_W'($past(rom_addr_o) + 1'b1) || rom_addr_o == '0));

  p_done_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_done_o && cfg_err_o));

  p_io_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode_o |-> (!tgt_cclk_o && tgt_prog_n_o));

  p_cpu_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_n |-> (io_rdata_o == '0));
endmodule

bind cfg_loader cfg_loader_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  localparam int ADDR_W = 8;
  localparam int IMG    = 4;
  localparam int DB     = 4;
  localparam int TMO    = 6;
  localparam int REG_W  = 8;
  localparam int NBITS  = IMG * 8;

  logic clk = 1'b0;
  logic rst_n, cpu_rst_n, btn, init_n, done_in;
  logic prog_n, cclk, dout, cfg_done, cfg_err, io_mode;
  logic [ADDR_W-1:0] rom_addr;
  logic [7:0] rom_q;
  logic io_we, io_addr;
  logic [REG_W-1:0] io_wdata, io_evt, io_rdata;

  int checks = 0;
  int fails  = 0;
  int nbits  = 0;
  int progs  = 0;
  logic bits [0:63];

  always #5 clk = ~clk;

  cfg_loader #(
    .ADDR_W(ADDR_W), .IMG_BYTES(IMG), .DB_CYCLES(DB), .DONE_TMO(TMO), .REG_W(REG_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_rst_n(cpu_rst_n), .btn_i(btn),
    .tgt_init_n_i(init_n), .tgt_done_i(done_in), .tgt_prog_n_o(prog_n),
    .tgt_cclk_o(cclk), .tgt_dout_o(dout), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .cfg_done_o(cfg_done), .cfg_err_o(cfg_err), .io_mode_o(io_mode),
    .io_we_i(io_we), .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_evt_i(io_evt),
    .io_rdata_o(io_rdata)
  );

  function automatic logic [7:0] rom_fn(input logic [ADDR_W-1:0] a);
    return 8'(a * 8'd53 + 8'hC6);
  endfunction

  // ROM model with one cycle of read latency
  always @(posedge clk) rom_q <= rom_fn(rom_addr);

  // target side monitors
  always @(posedge cclk) begin
    if (nbits < 64) bits[nbits] = dout;
    nbits++;
  end
  always @(negedge prog_n) progs++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_bits(input int n);
    for (int k = 0; k < 2000 && nbits < n; k++) @(negedge clk);
  endtask

  function automatic int bit_mismatches();
    int m = 0;
    for (int i = 0; i < NBITS; i++) begin
      logic [7:0] b = rom_fn(ADDR_W'(i / 8));
      if (bits[i] !== b[7 - (i % 8)]) m++;
    end
    return m;
  endfunction

  task automatic finish_ok_load(input string req);
    wait_bits(NBITS + 1);
    done_in = 1'b1;
    cyc(8);
    done_in = 1'b0;
    chk({req, " done"}, cfg_done, 1'b1);
    chk({req, " err"}, cfg_err, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 0; cpu_rst_n = 0; btn = 0; init_n = 1; done_in = 0;
    io_we = 0; io_addr = 0; io_wdata = '0; io_evt = '0;
    cyc(4);
    chk("R1 prog_n in reset", prog_n, 1'b1);
    rst_n = 1; cpu_rst_n = 1;
    cyc(6);
    chk("R1 prog_n", prog_n, 1'b1);
    chk("R1 cclk", cclk, 1'b0);
    chk("R1 done/err/io", {cfg_done, cfg_err, io_mode}, 3'b000);
  endtask

  task automatic t_init_request();
    int p0 = progs;
    nbits = 0;
    init_n = 1'b0;
    cyc(8);
    chk("R2 one prog pulse", progs - p0, 1);
    chk("R2 no cclk while init low", nbits, 0);
    init_n = 1'b1;
    finish_ok_load("R5");
    chk("R4 bit order vs ROM", bit_mismatches(), 0);
    chk("R9 io mode after success", io_mode, 1'b1);
    begin
      int nb = nbits;
      cyc(30);
      chk("R8 idle no cclk", nbits, nb);
      chk("R8 idle no prog", progs - p0, 1);
    end
  endtask

  task automatic t_io_bank();
    io_addr = 0; io_wdata = 8'hA5; io_we = 1; cyc(1); io_we = 0;
    #1 chk("R10 ctrl readback", io_rdata, 8'hA5);
    io_evt = 8'h12; cyc(1); io_evt = '0;
    io_addr = 1; #1 chk("R10 status set", io_rdata, 8'h12);
    io_evt = 8'h40; cyc(1); io_evt = '0;
    #1 chk("R10 status sticky", io_rdata, 8'h52);
    io_wdata = 8'h02; io_we = 1; cyc(1); io_we = 0;
    #1 chk("R10 status w1c", io_rdata, 8'h50);
  endtask

  task automatic t_cpu_reset();
    int nb = nbits;
    int p0 = progs;
    cpu_rst_n = 0;
    cyc(3);
    io_addr = 0; #1 chk("R11 ctrl cleared", io_rdata, 8'h00);
    io_addr = 1; #1 chk("R11 status cleared", io_rdata, 8'h00);
    cpu_rst_n = 1;
    cyc(10);
    chk("R11 loader kept", {cfg_done, io_mode}, 2'b11);
    chk("R11 no restart", (nbits - nb) + (progs - p0), 0);
    io_addr = 0; #1 chk("R11 ctrl after release", io_rdata, 8'h00);
  endtask

  task automatic t_timeout();
    nbits = 0;
    init_n = 1'b0;
    cyc(6);
    chk("R8 done held until shifting", cfg_done, 1'b1);
    init_n = 1'b1;
    for (int k = 0; k < 2000 && !cfg_err; k++) @(negedge clk);
    cyc(2);
    chk("R6 err set", {cfg_err, cfg_done}, 2'b10);
    chk("R6 extra pulses", nbits, NBITS + TMO);
    chk("R9 no io mode after failure", io_mode, 1'b0);
    begin
      int nb = nbits;
      cyc(20);
      chk("R8 idle after error", nbits, nb);
    end
  endtask

  task automatic t_io_ignored();
    io_addr = 0; io_wdata = 8'h3C; io_we = 1; io_evt = 8'hFF; cyc(1);
    io_we = 0; io_evt = '0;
    #1 chk("R9 ctrl write ignored", io_rdata, 8'h00);
    io_addr = 1; #1 chk("R9 event ignored", io_rdata, 8'h00);
  endtask

  task automatic t_init_abort();
    nbits = 0;
    init_n = 1'b0; cyc(3); init_n = 1'b1;
    wait_bits(10);
    init_n = 1'b0;
    cyc(6);
    chk("R7 err on init low", cfg_err, 1'b1);
    begin
      int nb = nbits;
      cyc(6);
      chk("R7 cclk stopped", nbits, nb);
      chk("R7 cclk low", cclk, 1'b0);
    end
    nbits = 0;
    init_n = 1'b1;
    finish_ok_load("R7 re-arm");
    chk("R4 bit order second load", bit_mismatches(), 0);
  endtask

  task automatic t_button();
    int p0 = progs;
    int nb = nbits;
    btn = 1'b1; cyc(2); btn = 1'b0;
    cyc(20);
    chk("R3 glitch ignored", (progs - p0) + (nbits - nb), 0);
    btn = 1'b1; cyc(10); btn = 1'b0;
    for (int k = 0; k < 30 && progs == p0; k++) @(negedge clk);
    chk("R3 long press starts load", progs - p0, 1);
    nbits = 0;
    finish_ok_load("R3");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_init_request();
    t_io_bank();
    t_cpu_reset();
    t_timeout();
    t_io_ignored();
    t_init_abort();
    t_button();
    summary();
  end
endmodule